// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial line. Its clock runs at sixteen times the bit rate, so every bit on the line occupies sixteen clock cycles. A one-entry holding register sits in front of the shift register. A character accepted on the input stream waits there until the shifter is free. It then moves into the shifter and leaves the block in this order: one low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and a high stop interval of one, one and a half or two bit times.

The input is a valid/ready stream, with one rule of its own for back-pressure. `in_ready` is high exactly when the holding register is empty, and it doubles as the buffer-empty flag. Every cycle in which `in_valid` is sampled high loads `in_data`, whatever the state of `in_ready`. A producer that honours `in_ready` never loses a character. A producer that ignores it replaces the waiting character, and the most recent character wins.

The format pins are sampled at the cycle a character moves into the shifter. They must stay stable from the moment a character is offered until that character has left the line. `eoc` is high while the line is idle and low while a character is being shifted out.

Top module: `atx_top`

## Requirements
- R1: After a synchronous reset, `txd`=1, `in_ready`=1 and `eoc`=1, even if a character was being shifted out when reset arrived.
- R2: Take the case where the shifter is idle, the buffer is empty and `in_valid` is sampled at edge k. Then `txd` stays high after edge k and is low from edge k+1. `in_ready` is low only between edges k and k+1.
- R3: The start bit is low for exactly 16 cycles. Every data bit and the parity bit each last exactly 16 cycles.
- R4: `data_len` code 0,1,2,3 selects 5,6,7,8 data bits. The bits are sent from `in_data[0]` upward, and bits above the selected width have no effect on the line.
- R5: With `par_en`=1, one parity bit follows the data. With `par_odd`=0 the number of ones over the data and parity bits is even; with `par_odd`=1 it is odd. With `par_en`=0 no parity bit is sent.
- R6: The stop interval is high for 16 cycles with `stop_sel`=0, 24 with `stop_sel`=1, and 32 with `stop_sel`=2 or 3.
- R7: `eoc` falls in the first start-bit cycle of a character and returns high only after the last stop cycle, provided no character is waiting.
- R8: When a character is waiting as the previous one ends, its start bit begins in the cycle right after the last stop cycle. There is no gap between the two, and `eoc` stays low across the boundary.
- R9: `in_ready` goes high at the edge where the waiting character moves into the shifter, which is the edge right after the previous character's last stop cycle.
- R10: When `in_valid` is sampled while the buffer is already full, the buffered character is replaced. Only the last one loaded is sent.
- R11: The line is high whenever no character is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16x the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Load strobe for `in_data` |
| in_data | input | DW (8) | Character to send |
| in_ready | output | 1 | Holding register empty |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| data_len | input | 2 | Data width code, 0..3 gives 5..8 bits |
| stop_sel | input | 2 | Stop interval: 0 = 1 bit, 1 = 1.5 bits, 2/3 = 2 bits |
| txd | output | 1 | Serial output, idle high |
| eoc | output | 1 | High while idle, low while shifting |

## Verification
The assertions check a handful of behaviours on every cycle: the line is high whenever `eoc` is high, the line is low from the first cycle of a new character and holds low for the full sixteen-cycle start bit, a strobe always leaves the buffer full, a waiting character on an idle line starts on the next edge, and reset returns all outputs to their idle state. The exact sequence of bits for every combination of data width, parity mode and stop length can only be shown by the bench's scenarios, as can the seamless hand-over between back-to-back characters, the point where `in_ready` rises, and the replacement of a buffered character. The bench checks these by comparing the line cycle by cycle against a waveform it computes itself.

// File: rtl/atx_pkg.sv
package atx_pkg;

  typedef struct packed {
    logic       par_en;
    logic       par_odd;
    logic [1:0] len_code;
    logic [1:0] stop_code;
  } fmt_t;

  // Length of the high stop interval in clock cycles for a stop code
  function automatic int stop_cycles(int ovs, logic [1:0] code);
    case (code)
      2'd0:    return ovs;
      2'd1:    return ovs + ovs / 2;
      default: return 2 * ovs;
    endcase
  endfunction

endpackage

// File: rtl/atx_holding.sv
module atx_holding #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (load) begin
      // a load in the same cycle as a take keeps the buffer occupied
      full <= 1'b1;
      data <= load_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/atx_frame_build.sv
module atx_frame_build
  import atx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16,
  parameter int FW  = DW + 2,
  parameter int CW  = 8
) (
  input  logic [DW-1:0] data,
  input  fmt_t          fmt,
  output logic [FW-1:0] frame,
  output logic [CW-1:0] len
);

  localparam int MINW = DW - 3;

  int   nbits;
  logic pbit;

  always_comb begin
    nbits = MINW + int'(fmt.len_code);
    pbit  = fmt.par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < nbits) begin
        frame[i+1] = data[i];
        pbit       = pbit ^ data[i];
      end
    end
    for (int i = 1; i < FW; i++) begin
      if (fmt.par_en && (i == nbits + 1)) frame[i] = pbit;
    end
    len = CW'(OVS * (1 + nbits + int'(fmt.par_en)) + stop_cycles(OVS, fmt.stop_code));
  end

endmodule

// File: rtl/atx_shift.sv
module atx_shift #(
  parameter int OVS = 16,
  parameter int FW  = 10,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [FW-1:0] frame,
  input  logic [CW-1:0] len,
  output logic          free,
  output logic          busy,
  output logic          line
);

  localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;

  logic [FW-1:0] sh;
  logic [CW-1:0] rem;
  logic [TW-1:0] tick;

  assign free = !busy || (rem == '0);
  assign line = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      busy <= 1'b0;
      rem  <= '0;
      tick <= '0;
    end else if (take) begin
      sh   <= frame;
      rem  <= len - CW'(1);
      tick <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (rem == '0) begin
        busy <= 1'b0;
        sh   <= '1;
      end else begin
        rem <= rem - CW'(1);
        if (tick == TW'(OVS - 1)) begin
          tick <= '0;
          sh   <= {1'b1, sh[FW-1:1]};
        end else begin
          tick <= tick + TW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/atx_top.sv
module atx_top
  import atx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic [1:0]    data_len,
  input  logic [1:0]    stop_sel,
  output logic          txd,
  output logic          eoc
);

  localparam int FW   = DW + 2;
  localparam int MAXL = OVS * FW + 2 * OVS;
  localparam int CW   = $clog2(MAXL + 1);

  fmt_t          fmt;
  logic          buf_full, sh_free, sh_busy, take;
  logic [DW-1:0] buf_data;
  logic [FW-1:0] frame;
  logic [CW-1:0] len;

  assign fmt  = '{par_en: par_en, par_odd: par_odd, len_code: data_len, stop_code: stop_sel};
  assign take = buf_full && sh_free;

  atx_holding #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .load(in_valid), .load_data(in_data),
    .take(take), .full(buf_full), .data(buf_data)
  );

  atx_frame_build #(.DW(DW), .OVS(OVS), .FW(FW), .CW(CW)) u_build (
    .data(buf_data), .fmt(fmt), .frame(frame), .len(len)
  );

  atx_shift #(.OVS(OVS), .FW(FW), .CW(CW)) u_shift (
    .clk(clk), .rst(rst), .take(take), .frame(frame), .len(len),
    .free(sh_free), .busy(sh_busy), .line(txd)
  );

  assign in_ready = !buf_full;
  assign eoc      = !sh_busy;

endmodule

// File: rtl/atx_checks.sv
module atx_checks #(
  parameter int OVS = 16
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic eoc
);

  logic [7:0] since_idle;

  // cycles since the line left idle, saturating at OVS
  always_ff @(posedge clk) begin
    if (rst)                     since_idle <= 8'(OVS);
    else if (eoc)                since_idle <= '0;
    else if (since_idle < 8'(OVS)) since_idle <= since_idle + 8'd1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (txd && in_ready && eoc)); // R1
  AST_PROMPT_START: assert property (@(posedge clk) disable iff (rst) (eoc && !in_ready) |=> !eoc); // R2
  AST_START_FULL: assert property (@(posedge clk) disable iff (rst) (!eoc && since_idle < 8'(OVS)) |-> !txd); // R3
  AST_START_SPACE: assert property (@(posedge clk) disable iff (rst) $fell(eoc) |-> !txd); // R7
  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (rst) in_valid |=> !in_ready); // R10
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst) eoc |-> txd); // R11

endmodule

bind atx_top atx_checks u_checks (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .txd(txd), .eoc(eoc)
);

// File: tb/tb_atx_top.sv
module tb_atx_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       par_en, par_odd;
  logic [1:0] data_len, stop_sel;
  logic       txd, eoc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  atx_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .par_en(par_en), .par_odd(par_odd), .data_len(data_len), .stop_sel(stop_sel),
    .txd(txd), .eoc(eoc)
  );

  function automatic int frame_len();
    int st;
    st = (stop_sel == 2'd0) ? 16 : (stop_sel == 2'd1) ? 24 : 32;
    return 16 * (1 + 5 + int'(data_len) + int'(par_en)) + st;
  endfunction

  function automatic logic exp_bit(logic [7:0] d, int j);
    int   n, b;
    logic p;
    n = 5 + int'(data_len);
    b = j / 16;
    if (b == 0) return 1'b0;
    if (b <= n) return d[b-1];
    if (par_en && b == n + 1) begin
      p = par_odd;
      for (int i = 0; i < n; i++) p = p ^ d[i];
      return p;
    end
    return 1'b1;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // compare one whole frame on the line, cycle by cycle; eoc must stay low
  task automatic watch(input logic [7:0] d, input string tag);
    int len, bad, at;
    logic ga, ge;
    len = frame_len();
    bad = 0; at = 0; ga = 1'b0; ge = 1'b0;
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      if (txd !== exp_bit(d, j) || eoc !== 1'b0) begin
        if (bad == 0) begin
          at = j; ga = txd; ge = exp_bit(d, j);
          if (eoc !== 1'b0) begin ga = eoc; ge = 1'b0; end
        end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: data %h cycle %0d got %b expected %b (%0d bad cycles)",
               tag, d, at, ga, ge, bad);
    end
  endtask

  task automatic strobe(input logic [7:0] d);
    in_data  = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle_checks(input string tag);
    @(negedge clk);
    check({tag, " R11 line high after frame"}, txd, 1'b1);
    check({tag, " R7 eoc back high"}, eoc, 1'b1);
    check({tag, " R9 buffer empty"}, in_ready, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lowc;
    rst = 1'b1; in_valid = 1'b0; in_data = '0;
    par_en = 1'b0; par_odd = 1'b0; data_len = 2'd3; stop_sel = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 txd after reset", txd, 1'b1);
    check("R1 in_ready after reset", in_ready, 1'b1);
    check("R1 eoc after reset", eoc, 1'b1);

    // sweep: every width, parity mode and stop code (R3 R4 R5 R6)
    for (int lc = 0; lc < 4; lc++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int ss = 0; ss < 4; ss++) begin
          for (int v = 0; v < 2; v++) begin
            logic [7:0] d;
            data_len = 2'(lc);
            par_en   = (pm != 0);
            par_odd  = (pm == 2);
            stop_sel = 2'(ss);
            d = (v == 0) ? 8'hE5 : 8'(lc * 37 + ss * 11 + pm * 5 + 8'h1A);
            strobe(d);
            check("R2 line still high one cycle after strobe", txd, 1'b1);
            check("R2 buffer full right after strobe", in_ready, 1'b0);
            watch(d, "R3 R4 R5 R6 frame");
            idle_checks("sweep");
          end
        end
      end
    end

    // back-to-back: 8 data, no parity, 1 stop (R8 R9)
    data_len = 2'd3; par_en = 1'b0; par_odd = 1'b0; stop_sel = 2'd0;
    lowc = 0;
    fork
      begin
        strobe(8'h5A);
        watch(8'h5A, "R8 first frame");
        watch(8'hC3, "R8 second frame follows without gap");
      end
      begin
        repeat (20) @(negedge clk);
        in_data = 8'hC3; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        while (in_ready == 1'b0 && lowc < 1000) begin
          lowc++;
          @(negedge clk);
        end
      end
    join
    check_int("R9 in_ready low until hand-over", lowc, 160 - 19);
    idle_checks("back-to-back");

    // overwrite while full: 7 data, even parity, 1.5 stop (R10)
    data_len = 2'd2; par_en = 1'b1; par_odd = 1'b0; stop_sel = 2'd1;
    fork
      begin
        strobe(8'h33);
        watch(8'h33, "R10 first frame");
        watch(8'h4E, "R10 last loaded character sent");
      end
      begin
        repeat (20) @(negedge clk);
        in_data = 8'h71; in_valid = 1'b1;
        @(negedge clk);
        in_data = 8'h4E;
        repeat (10) @(negedge clk);
        in_valid = 1'b0;
      end
    join
    idle_checks("overwrite");

    // reset in the middle of a frame (R1)
    strobe(8'h00);
    repeat (40) @(negedge clk);
    in_data = 8'hFF; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 txd after mid-frame reset", txd, 1'b1);
    check("R1 in_ready after mid-frame reset", in_ready, 1'b1);
    check("R1 eoc after mid-frame reset", eoc, 1'b1);
    repeat (40) @(negedge clk);
    check("R11 line stays high after reset", txd, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule